// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight status flags of an I2C controller. A separate bus engine reports what happens on the wire as single-cycle event pulses. These events are: a start generated or detected, a stop detected, an address or general-call match, a transmit byte handed to the shifter, a receive byte handed to the buffer, the ninth SCL rising edge, an SDA mismatch, and a missing acknowledge. The block turns these pulses into sticky flags. The CPU sees the flags through a status read port.

Software clears a flag by a two-step handshake. It first reads the status register while the flag is 1, which arms that bit. It then writes 0 to that bit. A status write always disarms every bit, whatever value it writes. A small access sequencer tracks the handshake with two states:

- `ACC_IDLE`: no bit is armed.
- `ACC_ARMED`: one or more bits are armed.

The sequencer has these transitions:

- `ACC_IDLE` to `ACC_ARMED`: a status read sees a nonzero flag value.
- `ACC_ARMED` to `ACC_ARMED`: a further status read adds the bits it sees as 1.
- `ACC_ARMED` to `ACC_IDLE`: any status write.
- `ACC_IDLE` to `ACC_IDLE`: any other cycle, including a read that sees all zeros.

If a read and a write strobe arrive in the same cycle, the write wins.

Writing the transmit data register clears both transmit flags. Reading the receive data register clears the receive flag. When a set event and any clear arrive in the same cycle, the set always wins.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset, `st_rdata` reads 8'h00 with the default `STOP_RST` of 0. The bit order from bit 7 down to bit 0 is: transmit-empty, transmit-end, receive-full, no-ack, stop, arbitration-lost, address-seen, general-call.
- R2: A status write of 0 to a flag that was not armed by an earlier read leaves the flag unchanged. Writing 1 to a flag never changes it.
- R3: A status read that sees a flag at 1 arms that bit. The next status write of 0 to that bit clears it. Every status write disarms all bits, so a later write of 0 without a new read clears nothing.
- R4: Transmit-empty (bit 7) sets on any of four events: a transmit byte loaded into the shifter, transmit mode selected, a start generated, or a change from slave receive to slave transmit.
- R5: Transmit-end (bit 6) sets on the ninth SCL rising edge only when bit 7 is 1 in that cycle.
- R6: A write of the transmit data register clears bits 7 and 6.
- R7: Receive-full (bit 5) sets when a receive byte moves to the buffer. A read of the receive data register clears it.
- R8: Arbitration-lost (bit 2) sets in two cases: an SDA mismatch while in master transmit, or a start detected with SDA high while in master mode. In any other mode these events are ignored.
- R9: In slave receive, an address match sets bit 1. A general call sets both bit 1 and bit 0. In any other mode, neither event has an effect.
- R10: No-ack (bit 4) sets on a missing acknowledge only while `ack_chk_en` is 1.
- R11: Stop (bit 3) sets when a stop condition is detected.
- R12: A set event in the same cycle as a software clear or a data-register clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Controller is in master mode |
| is_tx | input | 1 | Controller is transmitting |
| ack_chk_en | input | 1 | Enables no-ack flagging |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_tx_load | input | 1 | Transmit byte moved to shifter |
| ev_tx_mode | input | 1 | Transmit mode selected |
| ev_slv_to_tx | input | 1 | Slave receive changed to slave transmit |
| ev_rx_load | input | 1 | Receive byte moved to buffer |
| ev_scl9_rise | input | 1 | Ninth SCL rising edge |
| ev_sda_mismatch | input | 1 | Driven SDA differs from pin at SCL rise |
| ev_start_det | input | 1 | Start condition detected |
| sda_high_at_start | input | 1 | SDA pin high at start detection |
| ev_addr_match | input | 1 | First frame matched own address |
| ev_gcall | input | 1 | First frame was a general call |
| ev_stop_det | input | 1 | Stop condition detected |
| ev_nack | input | 1 | No acknowledge after a sent byte |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status write data |
| txd_wr | input | 1 | Transmit data register write strobe |
| rxd_rd | input | 1 | Receive data register read strobe |
| st_rdata | output | 8 | Current status flags |

## Verification
The hardest case to reach from the ports is a flag that is set while the clear handshake is in progress. This covers two situations. In the first, a bit is set after the read, so it was never armed. In the second, a set event arrives in the same cycle as the clearing write. The stimulus reads while a flag is 0, raises that flag, and then writes 0, expecting the flag to survive. It also pulses a set event together with the clearing write or data-register access. Partial clears are reached by arming two bits and writing back a pattern that clears only one of them. A second write then shows that nothing stays armed.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int NFLAG = 8;

    // Bit positions are fixed by the register layout software decodes
    localparam int B_ADZ   = 0;
    localparam int B_AAS   = 1;
    localparam int B_AL    = 2;
    localparam int B_STOP  = 3;
    localparam int B_NACKF = 4;
    localparam int B_RDRF  = 5;
    localparam int B_TEND  = 6;
    localparam int B_TDRE  = 7;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_ARMED = 1'b1
    } acc_state_t;

endpackage

// File: rtl/i2c_stat_cell.sv
module i2c_stat_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    logic q_nxt;

    // Set has priority so that no event is lost
    always_comb begin
        if (set)      q_nxt = 1'b1;
        else if (clr) q_nxt = 1'b0;
        else          q_nxt = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_nxt;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R12

    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(set)); // R2

endmodule

// File: rtl/i2c_stat_events.sv
module i2c_stat_events
    import i2c_stat_pkg::*;
(
    input  logic      is_master,
    input  logic      is_tx,
    input  logic      ack_chk_en,
    input  logic      ev_start_gen,
    input  logic      ev_tx_load,
    input  logic      ev_tx_mode,
    input  logic      ev_slv_to_tx,
    input  logic      ev_rx_load,
    input  logic      ev_scl9_rise,
    input  logic      ev_sda_mismatch,
    input  logic      ev_start_det,
    input  logic      sda_high_at_start,
    input  logic      ev_addr_match,
    input  logic      ev_gcall,
    input  logic      ev_stop_det,
    input  logic      ev_nack,
    input  logic      txd_wr,
    input  logic      rxd_rd,
    input  logic      tdre_now,
    output flag_vec_t set_vec,
    output flag_vec_t side_clr
);

    logic slave_rx;
    logic master_tx;

    assign slave_rx  = !is_master && !is_tx;
    assign master_tx = is_master && is_tx;

    always_comb begin
        set_vec          = '0;
        set_vec[B_TDRE]  = ev_tx_load | ev_tx_mode | ev_start_gen | ev_slv_to_tx;
        set_vec[B_TEND]  = ev_scl9_rise & tdre_now;
        set_vec[B_RDRF]  = ev_rx_load;
        set_vec[B_NACKF] = ev_nack & ack_chk_en;
        set_vec[B_STOP]  = ev_stop_det;
        set_vec[B_AL]    = (ev_sda_mismatch & master_tx)
                         | (ev_start_det & sda_high_at_start & is_master);
        set_vec[B_AAS]   = slave_rx & (ev_addr_match | ev_gcall);
        set_vec[B_ADZ]   = slave_rx & ev_gcall;
    end

    always_comb begin
        side_clr         = '0;
        side_clr[B_TDRE] = txd_wr;
        side_clr[B_TEND] = txd_wr;
        side_clr[B_RDRF] = rxd_rd;
    end

endmodule

// File: rtl/i2c_stat_access.sv
module i2c_stat_access
    import i2c_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      st_rd,
    input  logic      st_wr,
    input  flag_vec_t st_wdata,
    input  flag_vec_t flags,
    output flag_vec_t sw_clr
);

    acc_state_t state, state_nxt;
    flag_vec_t  arm, arm_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACC_IDLE;
            arm   <= '0;
        end else begin
            state <= state_nxt;
            arm   <= arm_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        arm_nxt   = arm;
        sw_clr    = '0;
        unique case (state)
            ACC_IDLE: begin
                if (!st_wr && st_rd && (flags != '0)) begin
                    state_nxt = ACC_ARMED;
                    arm_nxt   = flags;
                end
            end
            ACC_ARMED: begin
                if (st_wr) begin
                    sw_clr    = arm & ~st_wdata;
                    state_nxt = ACC_IDLE;
                    arm_nxt   = '0;
                end else if (st_rd) begin
                    arm_nxt   = arm | flags;
                end
            end
            default: begin
                state_nxt = ACC_IDLE;
                arm_nxt   = '0;
            end
        endcase
    end

    AST_IDLE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_IDLE) |-> (arm == '0)); // R3

    AST_WR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (state == ACC_IDLE)); // R3

    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr != '0) |-> (state == ACC_ARMED && st_wr)); // R2

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
#(
    parameter logic STOP_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master,
    input  logic       is_tx,
    input  logic       ack_chk_en,
    input  logic       ev_start_gen,
    input  logic       ev_tx_load,
    input  logic       ev_tx_mode,
    input  logic       ev_slv_to_tx,
    input  logic       ev_rx_load,
    input  logic       ev_scl9_rise,
    input  logic       ev_sda_mismatch,
    input  logic       ev_start_det,
    input  logic       sda_high_at_start,
    input  logic       ev_addr_match,
    input  logic       ev_gcall,
    input  logic       ev_stop_det,
    input  logic       ev_nack,
    input  logic       st_rd,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    input  logic       txd_wr,
    input  logic       rxd_rd,
    output logic [7:0] st_rdata
);

    flag_vec_t flags;
    flag_vec_t set_vec;
    flag_vec_t side_clr;
    flag_vec_t sw_clr;

    i2c_stat_events u_events (
        .is_master         (is_master),
        .is_tx             (is_tx),
        .ack_chk_en        (ack_chk_en),
        .ev_start_gen      (ev_start_gen),
        .ev_tx_load        (ev_tx_load),
        .ev_tx_mode        (ev_tx_mode),
        .ev_slv_to_tx      (ev_slv_to_tx),
        .ev_rx_load        (ev_rx_load),
        .ev_scl9_rise      (ev_scl9_rise),
        .ev_sda_mismatch   (ev_sda_mismatch),
        .ev_start_det      (ev_start_det),
        .sda_high_at_start (sda_high_at_start),
        .ev_addr_match     (ev_addr_match),
        .ev_gcall          (ev_gcall),
        .ev_stop_det       (ev_stop_det),
        .ev_nack           (ev_nack),
        .txd_wr            (txd_wr),
        .rxd_rd            (rxd_rd),
        .tdre_now          (flags[B_TDRE]),
        .set_vec           (set_vec),
        .side_clr          (side_clr)
    );

    i2c_stat_access u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_rd    (st_rd),
        .st_wr    (st_wr),
        .st_wdata (st_wdata),
        .flags    (flags),
        .sw_clr   (sw_clr)
    );

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        localparam logic RV = (gi == B_STOP) ? STOP_RST : 1'b0;
        i2c_stat_cell #(.RST_VAL(RV)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[gi]),
            .clr   (side_clr[gi] | sw_clr[gi]),
            .q     (flags[gi])
        );
    end

    assign st_rdata = flags;

    AST_TEND_NEEDS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_TEND]) |-> $past(ev_scl9_rise && flags[B_TDRE])); // R5

    AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !set_vec[B_TDRE]) |=> !flags[B_TDRE]); // R6

    AST_NACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_NACKF]) |-> $past(ack_chk_en)); // R10

    AST_ADZ_GCALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_ADZ]) |-> $past(ev_gcall && !is_master && !is_tx)); // R9

endmodule

// File: tb/i2c_stat_flags_bench.sv
module i2c_stat_flags_bench;

    localparam logic [16:0] M_START_GEN = 17'h00001;
    localparam logic [16:0] M_TX_LOAD   = 17'h00002;
    localparam logic [16:0] M_TX_MODE   = 17'h00004;
    localparam logic [16:0] M_SLV_TX    = 17'h00008;
    localparam logic [16:0] M_RX_LOAD   = 17'h00010;
    localparam logic [16:0] M_SCL9      = 17'h00020;
    localparam logic [16:0] M_SDA_MIS   = 17'h00040;
    localparam logic [16:0] M_START_DET = 17'h00080;
    localparam logic [16:0] M_SDA_HI    = 17'h00100;
    localparam logic [16:0] M_ADDR      = 17'h00200;
    localparam logic [16:0] M_GCALL     = 17'h00400;
    localparam logic [16:0] M_STOP      = 17'h00800;
    localparam logic [16:0] M_NACK      = 17'h01000;
    localparam logic [16:0] M_RD        = 17'h02000;
    localparam logic [16:0] M_WR        = 17'h04000;
    localparam logic [16:0] M_TXD_WR    = 17'h08000;
    localparam logic [16:0] M_RXD_RD    = 17'h10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b0, is_tx = 1'b0, ack_chk_en = 1'b0;
    logic [16:0] stim = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  st_rdata;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2.5 clk = ~clk;

    i2c_stat_flags u_i2c_stat_flags (
        .clk               (clk),
        .rst_n             (rst_n),
        .is_master         (is_master),
        .is_tx             (is_tx),
        .ack_chk_en        (ack_chk_en),
        .ev_start_gen      (stim[0]),
        .ev_tx_load        (stim[1]),
        .ev_tx_mode        (stim[2]),
        .ev_slv_to_tx      (stim[3]),
        .ev_rx_load        (stim[4]),
        .ev_scl9_rise      (stim[5]),
        .ev_sda_mismatch   (stim[6]),
        .ev_start_det      (stim[7]),
        .sda_high_at_start (stim[8]),
        .ev_addr_match     (stim[9]),
        .ev_gcall          (stim[10]),
        .ev_stop_det       (stim[11]),
        .ev_nack           (stim[12]),
        .st_rd             (stim[13]),
        .st_wr             (stim[14]),
        .st_wdata          (wdata),
        .txd_wr            (stim[15]),
        .rxd_rd            (stim[16]),
        .st_rdata          (st_rdata)
    );

    // Driver: one-cycle stimulus, expected register value pushed after the edge
    task automatic pulse(input logic [16:0] m, input logic [7:0] wd,
                         input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        stim  = m;
        wdata = wd;
        @(posedge clk);
        #1;
        stim  = '0;
        wdata = '0;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge after the update
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                item_t it;
                it = q.pop_front();
                n_vec++;
                if (st_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: st_rdata=%02h expected=%02h", it.tag, st_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected=<20000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pulse('0, 8'h00, 8'h00, "R1");

        pulse(M_STOP, 8'h00, 8'h08, "R11");
        pulse(M_WR,   8'h00, 8'h08, "R2");   // no prior read
        pulse(M_RD,   8'h00, 8'h08, "R3");
        pulse(M_WR,   8'h08, 8'h08, "R2");   // writing 1 keeps it, disarms
        pulse(M_WR,   8'h00, 8'h08, "R3");   // disarmed, no clear
        pulse(M_RD,   8'h00, 8'h08, "R3");
        pulse(M_WR,   8'h00, 8'h00, "R3");

        pulse(M_RX_LOAD, 8'h00, 8'h20, "R7");
        pulse(M_RXD_RD,  8'h00, 8'h00, "R7");

        pulse(M_SCL9,      8'h00, 8'h00, "R5");  // TDRE low: no TEND
        pulse(M_START_GEN, 8'h00, 8'h80, "R4");
        pulse(M_SCL9,      8'h00, 8'hC0, "R5");
        pulse(M_TXD_WR,    8'h00, 8'h00, "R6");
        pulse(M_TX_MODE,   8'h00, 8'h80, "R4");
        pulse(M_TXD_WR,    8'h00, 8'h00, "R6");
        pulse(M_TX_LOAD,   8'h00, 8'h80, "R4");
        pulse(M_TXD_WR,    8'h00, 8'h00, "R6");
        pulse(M_SLV_TX,    8'h00, 8'h80, "R4");
        pulse(M_SCL9,      8'h00, 8'hC0, "R5");
        pulse(M_TXD_WR | M_TX_LOAD, 8'h00, 8'h80, "R12");
        pulse(M_TXD_WR,    8'h00, 8'h00, "R6");

        ack_chk_en = 1'b0;
        pulse(M_NACK, 8'h00, 8'h00, "R10");
        ack_chk_en = 1'b1;
        pulse(M_NACK, 8'h00, 8'h10, "R10");
        pulse(M_RD,   8'h00, 8'h10, "R3");
        pulse(M_WR,   8'h00, 8'h00, "R3");

        is_master = 1'b0; is_tx = 1'b1;
        pulse(M_SDA_MIS, 8'h00, 8'h00, "R8");
        is_master = 1'b1;
        pulse(M_SDA_MIS, 8'h00, 8'h04, "R8");
        pulse(M_RD, 8'h00, 8'h04, "R3");
        pulse(M_WR, 8'h00, 8'h00, "R3");
        is_tx = 1'b0;
        pulse(M_START_DET, 8'h00, 8'h00, "R8");
        pulse(M_START_DET | M_SDA_HI, 8'h00, 8'h04, "R8");
        pulse(M_RD, 8'h00, 8'h04, "R3");
        pulse(M_WR, 8'h00, 8'h00, "R3");

        pulse(M_GCALL, 8'h00, 8'h00, "R9");     // master: ignored
        is_master = 1'b0;
        pulse(M_ADDR,  8'h00, 8'h02, "R9");
        pulse(M_GCALL, 8'h00, 8'h03, "R9");
        pulse(M_RD, 8'h00, 8'h03, "R3");
        pulse(M_WR, 8'h02, 8'h02, "R3");        // clears bit 0 only
        pulse(M_WR, 8'h00, 8'h02, "R3");        // disarmed
        pulse(M_RD, 8'h00, 8'h02, "R3");
        pulse(M_WR, 8'h00, 8'h00, "R3");

        pulse(M_STOP, 8'h00, 8'h08, "R11");
        pulse(M_RD,   8'h00, 8'h08, "R3");
        pulse(M_WR | M_STOP, 8'h00, 8'h08, "R12");
        pulse(M_RD,   8'h00, 8'h08, "R3");
        pulse(M_WR,   8'h00, 8'h00, "R3");

        pulse(M_RD,      8'h00, 8'h00, "R3");   // read sees 0: nothing armed
        pulse(M_RX_LOAD, 8'h00, 8'h20, "R7");
        pulse(M_WR,      8'h00, 8'h20, "R2");
        pulse(M_RXD_RD | M_RX_LOAD, 8'h00, 8'h20, "R12");
        pulse(M_RXD_RD,  8'h00, 8'h00, "R7");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule